// File: doc/BRIEF.md
# Chained Interrupt Bridge

This block is a second-level interrupt controller. It watches up to 32 event lines, records a rising edge on any of them as a sticky cause bit, and gates those bits with a per-source enable register. The enabled, recorded events are combined into one level output. That output is meant to drive a single input of a parent interrupt controller, so one parent input serves the whole group of sources.

Software programs the enable register and reads the cause register through a small register port. To acknowledge a source, software writes the cause register with a zero in that source's bit and ones in all other bits. A one leaves its bit as it is, so one write can clear a chosen subset of bits without a read-modify-write race against new events. The number of sources is a parameter. Bits above that count read as zero, and writes to them have no effect.

Top module: `chain_irq_bridge`

## Requirements
- R1: After reset the cause register (offset 0x0) and the enable register (offset 0x4) both read 0, and `irq_o` is low.
- R2: A 0-to-1 transition on `src_i[i]` sets cause bit i on the next clock edge. A source held high does not set the bit again after it has been cleared.
- R3: A write to offset 0x0 clears every cause bit whose write-data bit is 0 and leaves every bit whose write-data bit is 1 unchanged. The result is readable immediately after the clock edge on which the strobe was sampled.
- R4: When a rising edge on a source falls in the same cycle as a write that clears its cause bit, the bit ends up set.
- R5: A write to offset 0x4 loads the enable register, where 1 enables a source and 0 disables it. The register reads back at offset 0x4 after the clock edge of the write.
- R6: `irq_o` is high exactly one cycle after some bit is set in both the cause and enable registers. It stays high while such a bit remains, and it falls one cycle after the last such bit goes away.
- R7: Disabling a source does not clear its cause bit. A recorded event on a disabled source raises `irq_o` one cycle after the source is enabled.
- R8: Register bits at positions NUM_SRC and above read as 0. Writing ones to them changes nothing.
- R9: Reads from any offset other than 0x0 and 0x4 return 0. Writes to such offsets change neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| src_i | input | NUM_SRC | Event lines; a rising edge records an event |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational from register state |
| irq_o | output | 1 | Registered level output to the parent controller |

## Verification
The set path and the acknowledge path can hit the same cause bit in one cycle. A new rising edge may arrive on the edge that samples a zero-writing acknowledge. The bench provokes this by raising a source in the same half-cycle in which it drives a clear-all write to offset 0x0. It then judges the result by reading the cause register after that edge, where the contended bit must be set and the other bits cleared. The output is checked on the following cycle, where it must assert once the source is enabled.

// File: rtl/chain_irq_pkg.sv
package chain_irq_pkg;

  localparam int unsigned DATA_W    = 32;
  localparam int unsigned CAUSE_OFS = 0;
  localparam int unsigned ENABLE_OFS = 4;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_CAUSE  = 2'd1,
    SEL_ENABLE = 2'd2
  } reg_sel_e;

endpackage

// File: rtl/cib_rst_sync.sv
module cib_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/cib_regif.sv
module cib_regif #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic [ADDR_W-1:0]                      reg_addr,
  input  logic                                   reg_wr,
  input  logic [chain_irq_pkg::DATA_W-1:0]       reg_wdata,
  input  logic [NUM_SRC-1:0]                     cause,
  input  logic [NUM_SRC-1:0]                     enable,
  output logic                                   cause_wr,
  output logic                                   enable_wr,
  output logic [NUM_SRC-1:0]                     wdata_lo,
  output logic [chain_irq_pkg::DATA_W-1:0]       reg_rdata
);
  import chain_irq_pkg::*;

  reg_sel_e sel;

  always_comb begin
    if (reg_addr == ADDR_W'(CAUSE_OFS)) begin
      sel = SEL_CAUSE;
    end else if (reg_addr == ADDR_W'(ENABLE_OFS)) begin
      sel = SEL_ENABLE;
    end else begin
      sel = SEL_NONE;
    end
  end

  assign cause_wr  = reg_wr && (sel == SEL_CAUSE);
  assign enable_wr = reg_wr && (sel == SEL_ENABLE);
  assign wdata_lo  = reg_wdata[NUM_SRC-1:0];

  always_comb begin
    reg_rdata = '0;
    case (sel)
      SEL_CAUSE:  reg_rdata[NUM_SRC-1:0] = cause;
      SEL_ENABLE: reg_rdata[NUM_SRC-1:0] = enable;
      default:    reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/cib_cause_bank.sv
module cib_cause_bank #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               clr_en,
  input  logic [NUM_SRC-1:0] keep_mask,
  output logic [NUM_SRC-1:0] cause_q
);

  logic [NUM_SRC-1:0] src_q;
  logic [NUM_SRC-1:0] rise;
  logic [NUM_SRC-1:0] cause_d;
  logic               cause_en;

  // Per-source next state: a fresh edge wins over a zero-write clear.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    assign rise[i]    = src_i[i] & ~src_q[i];
    assign cause_d[i] = rise[i] | (cause_q[i] & ~(clr_en & ~keep_mask[i]));
  end

  assign cause_en = clr_en | (|rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
    end else begin
      src_q <= src_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
    end else if (cause_en) begin
      cause_q <= cause_d;
    end
  end

endmodule

// File: rtl/cib_enable_reg.sv
module cib_enable_reg #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] enable_q
);

  logic [NUM_SRC-1:0] enable_d;

  always_comb begin
    enable_d = enable_q;
    if (wr_en) begin
      enable_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
    end else if (wr_en) begin
      enable_q <= enable_d;
    end
  end

endmodule

// File: rtl/cib_aggregate.sv
module cib_aggregate #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] cause,
  input  logic [NUM_SRC-1:0] enable,
  output logic               irq_q
);

  logic [NUM_SRC-1:0] pending;
  logic               irq_d;

  assign pending = cause & enable;
  assign irq_d   = |pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

endmodule

// File: rtl/chain_irq_bridge.sv
module chain_irq_bridge #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NUM_SRC-1:0]                   src_i,
  input  logic [ADDR_W-1:0]                    reg_addr,
  input  logic                                 reg_wr,
  input  logic [chain_irq_pkg::DATA_W-1:0]     reg_wdata,
  output logic [chain_irq_pkg::DATA_W-1:0]     reg_rdata,
  output logic                                 irq_o
);

  if (NUM_SRC < 1 || NUM_SRC > chain_irq_pkg::DATA_W) begin : g_bad_cfg
    $error("NUM_SRC must lie between 1 and 32");
  end

  logic               rst_sync_n;
  logic [NUM_SRC-1:0] cause_vec;
  logic [NUM_SRC-1:0] enable_vec;
  logic [NUM_SRC-1:0] wdata_lo;
  logic               cause_wr;
  logic               enable_wr;

  cib_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cib_regif #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regif (
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .cause     (cause_vec),
    .enable    (enable_vec),
    .cause_wr  (cause_wr),
    .enable_wr (enable_wr),
    .wdata_lo  (wdata_lo),
    .reg_rdata (reg_rdata)
  );

  cib_cause_bank #(.NUM_SRC(NUM_SRC)) u_cause (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .src_i     (src_i),
    .clr_en    (cause_wr),
    .keep_mask (wdata_lo),
    .cause_q   (cause_vec)
  );

  cib_enable_reg #(.NUM_SRC(NUM_SRC)) u_enable (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (enable_wr),
    .wdata    (wdata_lo),
    .enable_q (enable_vec)
  );

  cib_aggregate #(.NUM_SRC(NUM_SRC)) u_agg (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .cause  (cause_vec),
    .enable (enable_vec),
    .irq_q  (irq_o)
  );

endmodule

// File: rtl/cib_checker.sv
module cib_checker #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 4
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic [NUM_SRC-1:0]                  src_i,
  input logic                                reg_wr,
  input logic [ADDR_W-1:0]                   reg_addr,
  input logic [chain_irq_pkg::DATA_W-1:0]    reg_wdata,
  input logic [NUM_SRC-1:0]                  cause,
  input logic [NUM_SRC-1:0]                  enable,
  input logic                                irq
);

  logic [NUM_SRC-1:0] src_seen_q;
  logic [NUM_SRC-1:0] edge_now;
  logic [NUM_SRC-1:0] wlo;
  logic               wr_cause;
  logic               wr_enable;
  logic               any_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_seen_q <= '0;
    end else begin
      src_seen_q <= src_i;
    end
  end

  assign edge_now  = src_i & ~src_seen_q;
  assign wlo       = reg_wdata[NUM_SRC-1:0];
  assign wr_cause  = reg_wr && (reg_addr == ADDR_W'(chain_irq_pkg::CAUSE_OFS));
  assign wr_enable = reg_wr && (reg_addr == ADDR_W'(chain_irq_pkg::ENABLE_OFS));
  assign any_pend  = |(cause & enable);

  // R2 and R4: an edge always leaves its bit set, clear write or not
  a_r4_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_now != '0) |=> ((cause & $past(edge_now)) == $past(edge_now)));

  // R2: no bit appears without an edge
  a_r2_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cause & ~$past(cause) & ~$past(edge_now)) == '0));

  // R3: zero-written bits are gone unless an edge hit them
  a_r3_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cause |=> ((cause & ~$past(wlo) & ~$past(edge_now)) == '0));

  // R3: without a cause write nothing is cleared
  a_r3_no_clear_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cause |=> ((~cause & $past(cause)) == '0));

  // R5 and R9: enable changes only on a write to its own offset
  a_r5_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_enable |=> $stable(enable));

  // R6: output follows pending state one cycle later
  a_r6_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    any_pend |=> irq);

  a_r6_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !any_pend |=> !irq);

endmodule

bind chain_irq_bridge cib_checker #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .src_i     (src_i),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .cause     (cause_vec),
  .enable    (enable_vec),
  .irq       (irq_o)
);

// File: tb/sim_chain_irq_bridge.sv
module sim_chain_irq_bridge;

  localparam int unsigned N  = 24;
  localparam int unsigned AW = 4;
  localparam logic [31:0] LIVE = 32'h00FF_FFFF;

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  src;
  logic [AW-1:0] addr;
  logic          wr;
  logic [31:0]   wdata;
  logic [31:0]   rdata;
  logic          irq;

  int checks;
  int fails;
  bit finished;

  chain_irq_bridge #(.NUM_SRC(N), .ADDR_W(AW)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src),
    .reg_addr  (addr),
    .reg_wr    (wr),
    .reg_wdata (wdata),
    .reg_rdata (rdata),
    .irq_o     (irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  // Write: driven at a falling edge, sampled on the next rising edge,
  // returns at the following falling edge with the result visible.
  task automatic reg_write(input logic [AW-1:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic reg_read(input logic [AW-1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
    addr = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    reg_read(4'h0, v); check("R1 cause after reset", v, 32'h0);
    reg_read(4'h4, v); check("R1 enable after reset", v, 32'h0);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_edge_capture();
    logic [31:0] v;
    src[3] = 1'b1;
    idle();
    reg_read(4'h0, v); check("R2 edge sets bit 3", v, 32'h8);
    check("R7 masked event keeps irq low", {31'b0, irq}, 32'h0);
    reg_write(4'h0, ~32'h8);
    reg_read(4'h0, v); check("R3 zero-write clears bit 3", v, 32'h0);
    idle(); idle();
    reg_read(4'h0, v); check("R2 held level does not re-set", v, 32'h0);
    src[3] = 1'b0;
    idle();
  endtask

  task automatic t_selective_clear();
    logic [31:0] v;
    src[1] = 1'b1; src[5] = 1'b1; src[7] = 1'b1;
    idle();
    src = '0;
    reg_read(4'h0, v); check("R2 three edges captured", v, 32'hA2);
    reg_write(4'h0, ~32'h20);
    reg_read(4'h0, v); check("R3 ones leave bits 1 and 7", v, 32'h82);
    reg_write(4'h0, 32'h0);
    reg_read(4'h0, v); check("R3 all-zero write clears all", v, 32'h0);
  endtask

  task automatic t_enable_output();
    logic [31:0] v;
    reg_write(4'h4, 32'h4);
    reg_read(4'h4, v); check("R5 enable readback", v, 32'h4);
    src[2] = 1'b1;
    idle();
    check("R6 irq not yet high on capture edge", {31'b0, irq}, 32'h0);
    idle();
    check("R6 irq high one cycle after pending", {31'b0, irq}, 32'h1);
    src[2] = 1'b0;
    idle(); idle();
    check("R6 irq stays high while pending", {31'b0, irq}, 32'h1);
    reg_write(4'h0, ~32'h4);
    check("R6 irq still high on clear edge", {31'b0, irq}, 32'h1);
    idle();
    check("R6 irq falls after clear", {31'b0, irq}, 32'h0);
    reg_write(4'h4, 32'h0);
  endtask

  task automatic t_masked_pending();
    logic [31:0] v;
    src[4] = 1'b1;
    idle();
    src[4] = 1'b0;
    idle(); idle();
    check("R7 disabled source keeps irq low", {31'b0, irq}, 32'h0);
    reg_write(4'h4, 32'h10);
    check("R7 irq low on enable edge", {31'b0, irq}, 32'h0);
    idle();
    check("R7 irq high after enable", {31'b0, irq}, 32'h1);
    reg_write(4'h4, 32'h0);
    reg_read(4'h0, v); check("R7 disabling keeps cause", v, 32'h10);
    idle();
    check("R7 irq low after disable", {31'b0, irq}, 32'h0);
    reg_write(4'h0, 32'h0);
  endtask

  task automatic t_set_wins();
    logic [31:0] v;
    src[6] = 1'b1; src[0] = 1'b1;
    idle();
    src = '0;
    idle();
    src[6] = 1'b1;
    reg_write(4'h0, 32'h0);
    reg_read(4'h0, v); check("R4 edge beats clear on bit 6", v, 32'h40);
    src[6] = 1'b0;
    reg_write(4'h4, 32'h40);
    idle();
    check("R4 surviving bit drives irq", {31'b0, irq}, 32'h1);
    reg_write(4'h0, 32'h0);
    reg_write(4'h4, 32'h0);
    idle();
  endtask

  task automatic t_upper_bits();
    logic [31:0] v;
    reg_write(4'h4, 32'hFFFF_FFFF);
    reg_read(4'h4, v); check("R8 enable upper bits read zero", v, LIVE);
    src[N-1] = 1'b1;
    idle();
    src = '0;
    reg_write(4'h0, 32'hFFFF_FFFF);
    reg_read(4'h0, v); check("R8 cause upper bits zero, ones keep", v, 32'h0080_0000);
    reg_write(4'h0, 32'h0);
    reg_write(4'h4, 32'h0);
  endtask

  task automatic t_bad_offset();
    logic [31:0] v;
    reg_write(4'h4, 32'h0000_0003);
    src[9] = 1'b1;
    idle();
    src = '0;
    reg_write(4'h8, 32'h0);
    reg_write(4'hC, 32'hFFFF_FFFF);
    reg_read(4'h4, v); check("R9 stray writes leave enable", v, 32'h3);
    reg_read(4'h0, v); check("R9 stray writes leave cause", v, 32'h200);
    reg_read(4'h8, v); check("R9 unmapped read 0x8", v, 32'h0);
    reg_read(4'hC, v); check("R9 unmapped read 0xC", v, 32'h0);
    reg_write(4'h0, 32'h0);
    reg_write(4'h4, 32'h0);
  endtask

  initial begin
    checks = 0; fails = 0; finished = 1'b0;
    rst_n = 1'b0; src = '0; addr = '0; wr = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_edge_capture();
    t_selective_clear();
    t_enable_output();
    t_masked_pending();
    t_set_wins();
    t_upper_bits();
    t_bad_offset();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule